// File: doc/BRIEF.md
# Display Command Byte Decoder

This block sits behind the serial receiver of a small greyscale display controller. Bytes arrive with a data/command select bit. Bytes flagged as commands are parsed by this block. The first byte of each command is an opcode. The decoder then collects as many argument bytes as that opcode needs and goes back to waiting for the next opcode. Bytes flagged as pixel data pass it by untouched.

Three opcodes change state. One sets the column window, one sets the row window, and one sets the remap register. Each of these raises a one-cycle load strobe that tells the address generator to reload its current position from the new start value. Opcodes that only tune analogue or timing settings are parsed and their arguments are dropped. An opcode the decoder does not know raises a one-cycle error pulse and is kept for inspection.

Top module: `disp_cmd_decoder`

## Requirements
- R1: Opcode 0x15 takes two arguments. The column window start becomes the first argument mod 64 and the end becomes the second argument mod 64. `col_load` pulses for one cycle, in the cycle after the second argument is accepted.
- R2: Opcode 0x75 takes two arguments. The row window start becomes the first argument mod 80 and the end becomes the second argument mod 80. `row_load` pulses for one cycle, in the cycle after the second argument is accepted.
- R3: Opcode 0xA0 takes one argument, which is stored unchanged in `remap_q`. `remap_load` pulses for one cycle after that argument.
- R4: Opcodes 0x81, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF each consume exactly one argument. The argument has no effect, and the byte after it is parsed as an opcode.
- R5: Opcodes 0x84, 0x85, 0x86, 0xA4 to 0xA7, 0xAE, 0xAF and 0xE3 take no argument and have no effect. The next byte is parsed as an opcode.
- R6: Opcode 0xB8 consumes exactly eight argument bytes with no effect. The ninth byte is parsed as an opcode.
- R7: Byte 0xFF in opcode position has no effect, raises no error, and leaves the decoder waiting for an opcode.
- R8: Any other byte in opcode position raises `bad_op_pulse` for one cycle, in the cycle after it is accepted. At the same time it is latched into `bad_op_code`, and the next byte is parsed as an opcode.
- R9: Bytes with `in_dc` high change nothing, even in the middle of a command's arguments.
- R10: After reset the column window is 0..63, the row window is 0..79, `remap_q` and `bad_op_code` are 0, and every strobe is low.
- R11: At most one of the three load strobes and the error pulse is high in any cycle.
- R12: Window outputs keep their old values until the last argument of their command has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is present this cycle |
| in_dc | input | 1 | 1 = pixel data byte, 0 = command byte |
| in_byte | input | 8 | Received byte |
| col_lo | output | 6 | Column window start |
| col_hi | output | 6 | Column window end |
| col_load | output | 1 | One-cycle strobe: column window set |
| row_lo | output | 7 | Row window start |
| row_hi | output | 7 | Row window end |
| row_load | output | 1 | One-cycle strobe: row window set |
| remap_q | output | 8 | Remap register |
| remap_load | output | 1 | One-cycle strobe: remap written |
| bad_op_pulse | output | 1 | One-cycle pulse on an unknown opcode |
| bad_op_code | output | 8 | Last unknown opcode |

## Verification
The bench follows each ignored-argument and zero-argument opcode with a write to the remap register. If an opcode's argument count were wrong, the remap opcode would be taken as an argument, or its argument would be taken as an opcode, and either an error pulse or a wrong `remap_q` would result.

The eight-argument opcode is fed bytes that are themselves valid opcodes, so a counter that ends early produces a spurious column strobe. Window arguments above 64 and above 160 show whether the modulo folding is correct. Data bytes are inserted between a window opcode and its arguments to check that they do not advance the argument count.

// File: rtl/disp_cmd_pkg.sv
package disp_cmd_pkg;

    localparam int ARGS_W = 4;

    typedef enum logic [2:0] {
        K_COL,
        K_ROW,
        K_REMAP,
        K_SKIP,
        K_FILLER,
        K_BAD
    } op_kind_e;

    typedef struct packed {
        op_kind_e          kind;
        logic [ARGS_W-1:0] nargs;
    } op_info_t;

    typedef struct packed {
        logic       fire;
        op_kind_e   kind;
        logic [7:0] first;
        logic [7:0] last;
        logic [7:0] opcode;
    } commit_t;

    function automatic op_info_t classify(input logic [7:0] op);
        op_info_t r;
        unique case (op)
            8'h15:  r = '{kind: K_COL,   nargs: 4'd2};
            8'h75:  r = '{kind: K_ROW,   nargs: 4'd2};
            8'hA0:  r = '{kind: K_REMAP, nargs: 4'd1};
            8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
            8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF:
                    r = '{kind: K_SKIP,  nargs: 4'd1};
            8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6, 8'hA7,
            8'hAE, 8'hAF, 8'hE3:
                    r = '{kind: K_SKIP,  nargs: 4'd0};
            8'hB8:  r = '{kind: K_SKIP,  nargs: 4'd8};
            8'hFF:  r = '{kind: K_FILLER, nargs: 4'd0};
            default: r = '{kind: K_BAD,  nargs: 4'd0};
        endcase
        return r;
    endfunction

    function automatic logic [7:0] fold(input logic [7:0] v, input int unsigned lim);
        int unsigned t;
        t = 32'(v) % lim;
        return t[7:0];
    endfunction

endpackage

// File: rtl/disp_op_classify.sv
module disp_op_classify
    import disp_cmd_pkg::*;
(
    input  logic [7:0] op,
    output op_info_t   info
);
    always_comb info = classify(op);
endmodule

// File: rtl/disp_cmd_seq.sv
module disp_cmd_seq
    import disp_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic [7:0] byte_in,
    input  op_info_t   info,
    output commit_t    cmt
);
    logic              busy;
    op_kind_e          held_kind;
    logic [7:0]        held_op;
    logic [ARGS_W-1:0] held_n;
    logic [ARGS_W-1:0] cnt;
    logic [7:0]        arg0;
    logic              last_arg;

    assign last_arg = busy && ((cnt + 1'b1) == held_n);

    always_comb begin
        cmt = '0;
        if (take) begin
            if (!busy) begin
                if (info.nargs == '0) begin
                    cmt.fire   = 1'b1;
                    cmt.kind   = info.kind;
                    cmt.first  = byte_in;
                    cmt.last   = byte_in;
                    cmt.opcode = byte_in;
                end
            end else if (last_arg) begin
                cmt.fire   = 1'b1;
                cmt.kind   = held_kind;
                cmt.first  = (cnt == '0) ? byte_in : arg0;
                cmt.last   = byte_in;
                cmt.opcode = held_op;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            cnt       <= '0;
            held_kind <= K_SKIP;
            held_op   <= '0;
            held_n    <= '0;
            arg0      <= '0;
        end else if (take) begin
            if (!busy) begin
                if (info.nargs != '0) begin
                    busy      <= 1'b1;
                    held_kind <= info.kind;
                    held_op   <= byte_in;
                    held_n    <= info.nargs;
                    cnt       <= '0;
                end
            end else begin
                if (cnt == '0) arg0 <= byte_in;
                if (last_arg) begin
                    busy <= 1'b0;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_CNT_BELOW_COUNT: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < held_n)); // R6
    AST_HELD_KIND_VALID: assert property (@(posedge clk) disable iff (rst)
        busy |-> (held_kind != K_BAD && held_kind != K_FILLER)); // R8
endmodule

// File: rtl/disp_win_regs.sv
module disp_win_regs
    import disp_cmd_pkg::*;
#(
    parameter int NUM_COLS = 64,
    parameter int NUM_ROWS = 80,
    localparam int COL_W = $clog2(NUM_COLS),
    localparam int ROW_W = $clog2(NUM_ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  commit_t          cmt,
    output logic [COL_W-1:0] col_lo,
    output logic [COL_W-1:0] col_hi,
    output logic             col_load,
    output logic [ROW_W-1:0] row_lo,
    output logic [ROW_W-1:0] row_hi,
    output logic             row_load,
    output logic [7:0]       remap_q,
    output logic             remap_load,
    output logic             bad_op_pulse,
    output logic [7:0]       bad_op_code
);
    logic [7:0] c_first, c_last, r_first, r_last;

    always_comb begin
        c_first = fold(cmt.first, NUM_COLS);
        c_last  = fold(cmt.last,  NUM_COLS);
        r_first = fold(cmt.first, NUM_ROWS);
        r_last  = fold(cmt.last,  NUM_ROWS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_lo       <= '0;
            col_hi       <= COL_W'(NUM_COLS - 1);
            row_lo       <= '0;
            row_hi       <= ROW_W'(NUM_ROWS - 1);
            remap_q      <= '0;
            bad_op_code  <= '0;
            col_load     <= 1'b0;
            row_load     <= 1'b0;
            remap_load   <= 1'b0;
            bad_op_pulse <= 1'b0;
        end else begin
            col_load     <= 1'b0;
            row_load     <= 1'b0;
            remap_load   <= 1'b0;
            bad_op_pulse <= 1'b0;
            if (cmt.fire) begin
                unique case (cmt.kind)
                    K_COL: begin
                        col_lo   <= c_first[COL_W-1:0];
                        col_hi   <= c_last[COL_W-1:0];
                        col_load <= 1'b1;
                    end
                    K_ROW: begin
                        row_lo   <= r_first[ROW_W-1:0];
                        row_hi   <= r_last[ROW_W-1:0];
                        row_load <= 1'b1;
                    end
                    K_REMAP: begin
                        remap_q    <= cmt.last;
                        remap_load <= 1'b1;
                    end
                    K_BAD: begin
                        bad_op_code  <= cmt.opcode;
                        bad_op_pulse <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_COL_END_RANGE: assert property (@(posedge clk) disable iff (rst)
        (32'(col_hi) < NUM_COLS) && (32'(col_lo) < NUM_COLS)); // R1
    AST_ROW_END_RANGE: assert property (@(posedge clk) disable iff (rst)
        (32'(row_hi) < NUM_ROWS) && (32'(row_lo) < NUM_ROWS)); // R2
    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({col_load, row_load, remap_load, bad_op_pulse})); // R11
    AST_COL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !col_load |-> $stable(col_lo)); // R12
endmodule

// File: rtl/disp_cmd_decoder.sv
module disp_cmd_decoder
    import disp_cmd_pkg::*;
#(
    parameter int NUM_COLS = 64,
    parameter int NUM_ROWS = 80,
    localparam int COL_W = $clog2(NUM_COLS),
    localparam int ROW_W = $clog2(NUM_ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_dc,
    input  logic [7:0]       in_byte,
    output logic [COL_W-1:0] col_lo,
    output logic [COL_W-1:0] col_hi,
    output logic             col_load,
    output logic [ROW_W-1:0] row_lo,
    output logic [ROW_W-1:0] row_hi,
    output logic             row_load,
    output logic [7:0]       remap_q,
    output logic             remap_load,
    output logic             bad_op_pulse,
    output logic [7:0]       bad_op_code
);
    logic     take;
    op_info_t info;
    commit_t  cmt;

    assign take = in_valid && !in_dc;

    disp_op_classify u_cls (.op(in_byte), .info(info));

    disp_cmd_seq u_seq (
        .clk(clk), .rst(rst), .take(take), .byte_in(in_byte),
        .info(info), .cmt(cmt)
    );

    disp_win_regs #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS)) u_regs (
        .clk(clk), .rst(rst), .cmt(cmt),
        .col_lo(col_lo), .col_hi(col_hi), .col_load(col_load),
        .row_lo(row_lo), .row_hi(row_hi), .row_load(row_load),
        .remap_q(remap_q), .remap_load(remap_load),
        .bad_op_pulse(bad_op_pulse), .bad_op_code(bad_op_code)
    );

    AST_DATA_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_dc) |=> !(col_load || row_load || remap_load || bad_op_pulse)); // R9
    AST_BAD_CODE_MATCH: assert property (@(posedge clk) disable iff (rst)
        bad_op_pulse |-> ($past(take) && bad_op_code == $past(in_byte))); // R8
    AST_BAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (bad_op_pulse && !$past(take)) |-> 1'b0); // R8
endmodule

// File: tb/test_disp_cmd_decoder.sv
module test_disp_cmd_decoder;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_dc = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic [5:0] col_lo, col_hi;
    logic [6:0] row_lo, row_hi;
    logic [7:0] remap_q, bad_op_code;
    logic col_load, row_load, remap_load, bad_op_pulse;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    disp_cmd_decoder i_disp_cmd_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dc(in_dc), .in_byte(in_byte),
        .col_lo(col_lo), .col_hi(col_hi), .col_load(col_load),
        .row_lo(row_lo), .row_hi(row_hi), .row_load(row_load),
        .remap_q(remap_q), .remap_load(remap_load),
        .bad_op_pulse(bad_op_pulse), .bad_op_code(bad_op_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // drive one byte for one cycle; returns at the falling edge after it was taken
    task automatic send(input logic dc, input logic [7:0] b);
        in_valid = 1'b1;
        in_dc    = dc;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
        in_dc    = 1'b0;
    endtask

    task automatic no_strobes(input string req);
        chk(req, {col_load, row_load, remap_load, bad_op_pulse}, 0);
    endtask

    task automatic t_reset;
        chk("R10 col_lo", col_lo, 0);
        chk("R10 col_hi", col_hi, 63);
        chk("R10 row_lo", row_lo, 0);
        chk("R10 row_hi", row_hi, 79);
        chk("R10 remap", remap_q, 0);
        chk("R10 bad code", bad_op_code, 0);
        no_strobes("R10 strobes");
    endtask

    task automatic t_col;
        send(1'b0, 8'h15);
        send(1'b0, 8'h03);
        chk("R12 col_lo held", col_lo, 0);
        chk("R12 no col_load", col_load, 0);
        send(1'b0, 8'h46);
        chk("R1 col_load", col_load, 1);
        chk("R1 col_lo", col_lo, 3);
        chk("R1 col_hi mod", col_hi, 6);
        no_strobes_after();
    endtask

    task automatic no_strobes_after;
        @(negedge clk);
        no_strobes("R11 single cycle");
    endtask

    task automatic t_row;
        send(1'b0, 8'h75);
        send(1'b0, 8'h55);
        send(1'b0, 8'hC8);
        chk("R2 row_load", row_load, 1);
        chk("R2 row_lo mod", row_lo, 5);
        chk("R2 row_hi mod", row_hi, 40);
        chk("R11 col_load low", col_load, 0);
        no_strobes_after();
    endtask

    task automatic t_remap(input string req, input logic [7:0] v);
        send(1'b0, 8'hA0);
        send(1'b0, v);
        chk({req, " remap_load"}, remap_load, 1);
        chk({req, " remap"}, remap_q, v);
        chk({req, " no error"}, bad_op_pulse, 0);
    endtask

    task automatic t_one_arg;
        logic [7:0] ops [11] = '{8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD, 8'hB1,
                                 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF};
        for (int i = 0; i < 11; i++) begin
            send(1'b0, ops[i]);
            send(1'b0, 8'h99);
            no_strobes("R4 arg dropped");
            t_remap("R4", 8'(i + 8'h10));
        end
    endtask

    task automatic t_zero_arg;
        logic [7:0] ops [10] = '{8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5,
                                 8'hA6, 8'hA7, 8'hAE, 8'hAF, 8'hE3};
        for (int i = 0; i < 10; i++) begin
            send(1'b0, ops[i]);
            no_strobes("R5 no effect");
            t_remap("R5", 8'(i + 8'h40));
        end
    endtask

    task automatic t_grey;
        send(1'b0, 8'hB8);
        for (int i = 0; i < 8; i++) begin
            send(1'b0, 8'h15);
            no_strobes("R6 arg consumed");
        end
        t_remap("R6", 8'h33);
        chk("R6 col_lo untouched", col_lo, 3);
    endtask

    task automatic t_filler;
        send(1'b0, 8'hFF);
        no_strobes("R7 filler");
        t_remap("R7", 8'h5A);
    endtask

    task automatic t_bad;
        send(1'b0, 8'h42);
        chk("R8 pulse", bad_op_pulse, 1);
        chk("R8 code", bad_op_code, 8'h42);
        @(negedge clk);
        chk("R8 pulse one cycle", bad_op_pulse, 0);
        chk("R8 code kept", bad_op_code, 8'h42);
        t_remap("R8", 8'h77);
    endtask

    task automatic t_data;
        send(1'b1, 8'h42);
        no_strobes("R9 data idle");
        send(1'b0, 8'h15);
        send(1'b1, 8'hAA);
        send(1'b1, 8'hBB);
        chk("R9 col_lo", col_lo, 3);
        send(1'b0, 8'h02);
        send(1'b1, 8'h15);
        send(1'b0, 8'h09);
        chk("R9 col_load", col_load, 1);
        chk("R9 col_lo", col_lo, 2);
        chk("R9 col_hi", col_hi, 9);
        chk("R9 no error", bad_op_code, 8'h42);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_col();
        t_row();
        t_remap("R3", 8'h52);
        t_one_arg();
        t_zero_arg();
        t_grey();
        t_filler();
        t_bad();
        t_data();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule